// File: doc/BRIEF.md
# Keystream Generator Reseed Controller

This block drives a random number generator built on a stream cipher. It takes a seed from an entropy mixer, or from the host when test mode is on. It hands the seed fields to an external cipher core that produces 512-bit blocks. It then breaks each block into 32-bit words and writes them into an internal output FIFO, which the application drains. The cipher core is outside this block. The controller issues a one-cycle init pulse after each seed load. It issues one next pulse per block and waits for the core's valid pulse before asking again.

A seed is 960 bits wide. It holds a 256-bit key, a 128-bit nonce, a 64-bit start counter and a 512-bit data block. The controller presents the data block to the core for every block it requests. It counts the blocks written since the last seed. It asks for a fresh seed when that count reaches a limit set at a port, or when the host raises a force request. Generation stalls while the FIFO cannot hold a whole block.

Top module: `csprng_reseed_ctrl`

## Requirements
- R1: After reset, `ready` is 0, `seed_req` is 1 and `rd_vld` is 0. No `core_next` pulse is issued before the first seed is loaded.
- R2: The 960-bit seed is laid out with the key in bits [255:0], the nonce in [383:256], the start counter in [447:384] and the data block in [959:448]. The seed is accepted on a clock edge where `seed_req` and the selected valid are both high. In the following cycle, `core_init` is high for exactly one cycle and the core ports show the captured fields.
- R3: The round count is captured at each seed load. A `rounds_cfg` of 0 selects 20 rounds; any other value is used as given.
- R4: Each 512-bit block leaves the FIFO as 16 words, least significant word (bits [31:0]) first, in the order the blocks were produced.
- R5: When `reseed_limit` is nonzero, exactly that many blocks are written after a seed load, and then `seed_req` rises. The block count restarts from zero at each load. A limit of 0 disables the automatic reseed.
- R6: A pulse on `force_reseed` while generation is stalled on a full FIFO raises `seed_req` without requesting another block. Words already in the FIFO remain readable.
- R7: A `force_reseed` pulse that arrives while `seed_req` is already high is absorbed into that reseed. After the new seed loads, no further seed request follows from it.
- R8: `core_next` is issued only when the FIFO has room for a full block of 16 words. With no reads, exactly FIFO_DEPTH/16 blocks are generated before a stall.
- R9: With `test_mode` high, only the host seed port is accepted, and a valid on the mixer port has no effect. With `test_mode` low, only the mixer port is accepted.
- R10: `ready` rises at the first seed load and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mix_seed_vld | input | 1 | Mixer seed valid |
| mix_seed | input | 960 | Mixer seed |
| host_seed_vld | input | 1 | Host seed valid (test mode) |
| host_seed | input | 960 | Host seed (test mode) |
| test_mode | input | 1 | Selects host seed source |
| force_reseed | input | 1 | Host reseed request pulse |
| reseed_limit | input | 16 | Blocks per seed, 0 = no automatic reseed |
| rounds_cfg | input | 5 | Round count, 0 = default |
| seed_req | output | 1 | Controller waits for a seed |
| ready | output | 1 | A seed has been loaded since reset |
| core_init | output | 1 | Core init pulse |
| core_next | output | 1 | Request for one block |
| core_key | output | 256 | Key to core |
| core_iv | output | 128 | Nonce to core |
| core_ctr | output | 64 | Start counter to core |
| core_rounds | output | 5 | Round count to core |
| core_data | output | 512 | Data block to core |
| core_vld | input | 1 | Core block valid pulse |
| core_blk | input | 512 | Core output block |
| rd_en | input | 1 | Pop one word |
| rd_data | output | 32 | Head word of FIFO |
| rd_vld | output | 1 | FIFO not empty |

## Verification
The hardest state to reach is a force request that arrives while generation has stalled on a full FIFO. The same request is then repeated while the seed is still outstanding. The bench reaches this state by reading nothing until the stall has set in, which it confirms from the count of `core_next` pulses. It then pulses the force twice around the rise of `seed_req` and only then pushes the expected words. The scoreboard therefore checks that the old-seed blocks drain first, followed by new-seed blocks, and that no second reseed occurs.

// File: rtl/csprng_pkg.sv
// Shared widths and the seed layout of the reseed controller.
// Assumes the seed fields are packed data, counter, nonce, key from MSB to LSB.
package csprng_pkg;
    localparam int KEY_W   = 256;
    localparam int IV_W    = 128;
    localparam int CTR_W   = 64;
    localparam int BLK_W   = 512;
    localparam int WORD_W  = 32;
    localparam int SEED_W  = KEY_W + IV_W + CTR_W + BLK_W;
    localparam int ROUND_W = 5;

    typedef struct packed {
        logic [BLK_W-1:0] data;
        logic [CTR_W-1:0] ctr;
        logic [IV_W-1:0]  iv;
        logic [KEY_W-1:0] key;
    } seed_t;

    typedef enum logic [2:0] {
        ST_SEED, ST_LOAD, ST_GEN, ST_WAIT, ST_WRITE
    } ctrl_st_t;
endpackage

// File: rtl/csprng_word_fifo.sv
// Synchronous show-ahead word FIFO with an occupancy count.
// Assumes DEPTH is a power of two and the writer never writes when full.
module csprng_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic          rd_vld,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          pop;

    assign rd_vld  = (count != '0);
    assign rd_data = mem[rp];
    assign pop     = rd_en && rd_vld;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_en) wp <= wp + 1'b1;
            if (pop)   rp <= rp + 1'b1;
            case ({wr_en, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/csprng_blk_writer.sv
// Serialises one block into consecutive words, lowest word first.
// Assumes start is raised only when not busy.
module csprng_blk_writer #(
    parameter int BLK_W  = 512,
    parameter int WORD_W = 32,
    localparam int NW    = BLK_W / WORD_W,
    localparam int IW    = $clog2(NW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  blk,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              done
);
    logic [BLK_W-1:0] hold;
    logic [IW-1:0]    idx;
    logic             busy;

    assign wr_en   = busy;
    assign wr_data = hold[idx*WORD_W +: WORD_W];
    assign done    = busy && (idx == IW'(NW - 1));

    // Capture a block and step through its words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            hold <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
            hold <= blk;
        end else if (busy) begin
            idx  <= idx + 1'b1;
            if (done) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/csprng_reseed_ctrl.sv
// Reseed controller for a block-based keystream generator.
// Captures seeds, sequences an external cipher core, writes its blocks into
// the output FIFO and decides when a new seed is needed. Assumes the core
// accepts core_next from the cycle after core_init and answers each request
// with one core_vld pulse.
module csprng_reseed_ctrl
    import csprng_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int FIFO_DEPTH     = 64,
    parameter int DEFAULT_ROUNDS = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mix_seed_vld,
    input  logic [SEED_W-1:0]   mix_seed,
    input  logic                host_seed_vld,
    input  logic [SEED_W-1:0]   host_seed,
    input  logic                test_mode,
    input  logic                force_reseed,
    input  logic [CNT_W-1:0]    reseed_limit,
    input  logic [ROUND_W-1:0]  rounds_cfg,
    output logic                seed_req,
    output logic                ready,
    output logic                core_init,
    output logic                core_next,
    output logic [KEY_W-1:0]    core_key,
    output logic [IV_W-1:0]     core_iv,
    output logic [CTR_W-1:0]    core_ctr,
    output logic [ROUND_W-1:0]  core_rounds,
    output logic [BLK_W-1:0]    core_data,
    input  logic                core_vld,
    input  logic [BLK_W-1:0]    core_blk,
    input  logic                rd_en,
    output logic [WORD_W-1:0]   rd_data,
    output logic                rd_vld
);
    localparam int BLK_WORDS = BLK_W / WORD_W;
    localparam int FCW       = $clog2(FIFO_DEPTH + 1);
    localparam logic [FCW-1:0] FILL_MAX = FCW'(FIFO_DEPTH - BLK_WORDS);

    ctrl_st_t           st;
    seed_t              seed_q;
    logic               sel_vld, seed_take, pend, drop, wr_start, wr_done;
    logic               fifo_wr, limit_hit, room;
    logic [WORD_W-1:0]  fifo_wdata;
    logic [FCW-1:0]     fifo_count;
    logic [CNT_W-1:0]   blk_cnt;
    logic [SEED_W-1:0]  sel_seed;

    // Seed source selection: test mode takes the host port only.
    always_comb begin
        sel_vld  = test_mode ? host_seed_vld : mix_seed_vld;
        sel_seed = test_mode ? host_seed     : mix_seed;
    end

    assign seed_req  = (st == ST_SEED);
    assign seed_take = seed_req && sel_vld;
    assign core_init = (st == ST_LOAD);
    assign room      = (fifo_count <= FILL_MAX);
    assign core_next = (st == ST_GEN) && !pend && room;
    assign drop      = pend || force_reseed;
    assign wr_start  = (st == ST_WAIT) && core_vld && !drop;
    assign limit_hit = (reseed_limit != '0) && (blk_cnt == reseed_limit);

    assign core_key  = seed_q.key;
    assign core_iv   = seed_q.iv;
    assign core_ctr  = seed_q.ctr;
    assign core_data = seed_q.data;

    // Sequencing of seed load, block request and block write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_SEED;
        end else begin
            case (st)
                ST_SEED:  if (seed_take) st <= ST_LOAD;
                ST_LOAD:  st <= ST_GEN;
                ST_GEN:   if (pend) st <= ST_SEED;
                          else if (room) st <= ST_WAIT;
                ST_WAIT:  if (core_vld) st <= drop ? ST_SEED : ST_WRITE;
                ST_WRITE: if (wr_done)
                              st <= (drop || limit_hit) ? ST_SEED : ST_GEN;
                default:  st <= ST_SEED;
            endcase
        end
    end

    // Pending force flag; requests during a reseed merge into it.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pend <= 1'b0;
        else if (st == ST_SEED)             pend <= 1'b0;
        else if (force_reseed)              pend <= 1'b1;
    end

    // Seed, round count and readiness capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q      <= '0;
            core_rounds <= ROUND_W'(DEFAULT_ROUNDS);
            ready       <= 1'b0;
        end else if (seed_take) begin
            seed_q      <= seed_t'(sel_seed);
            core_rounds <= (rounds_cfg == '0) ? ROUND_W'(DEFAULT_ROUNDS) : rounds_cfg;
            ready       <= 1'b1;
        end
    end

    // Blocks written since the last seed load.
    always_ff @(posedge clk) begin
        if (!rst_n)         blk_cnt <= '0;
        else if (seed_take) blk_cnt <= '0;
        else if (wr_start)  blk_cnt <= blk_cnt + 1'b1;
    end

    csprng_blk_writer #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_writer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wr_start),
        .blk     (core_blk),
        .wr_en   (fifo_wr),
        .wr_data (fifo_wdata),
        .done    (wr_done)
    );

    csprng_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr),
        .wr_data (fifo_wdata),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .rd_vld  (rd_vld),
        .count   (fifo_count)
    );
endmodule

// File: rtl/csprng_reseed_chk.sv
// Property checker for the reseed controller, attached by bind.
// Assumes the internal names of the controller as connected below.
module csprng_reseed_chk #(
    parameter int CNT_W   = 16,
    parameter int FCW     = 7,
    parameter int DEPTH   = 64,
    parameter int ROUND_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ready,
    input logic               seed_req,
    input logic               seed_take,
    input logic               core_init,
    input logic               core_next,
    input logic [ROUND_W-1:0] core_rounds,
    input logic [CNT_W-1:0]   blk_cnt,
    input logic               fifo_wr,
    input logic [FCW-1:0]     fifo_count
);
    // R1
    next_needs_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_next |-> (ready && !seed_req));
    // R2
    init_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_take |=> core_init);
    // R3
    rounds_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_init |-> (core_rounds != '0));
    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_init |-> (blk_cnt == '0));
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_count < FCW'(DEPTH)));
    // R8
    room_on_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_next |-> (fifo_count <= FCW'(DEPTH - 16)));
    // R10
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

bind csprng_reseed_ctrl csprng_reseed_chk #(
    .CNT_W(CNT_W), .FCW(FCW), .DEPTH(FIFO_DEPTH), .ROUND_W(csprng_pkg::ROUND_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .seed_req    (seed_req),
    .seed_take   (seed_take),
    .core_init   (core_init),
    .core_next   (core_next),
    .core_rounds (core_rounds),
    .blk_cnt     (blk_cnt),
    .fifo_wr     (fifo_wr),
    .fifo_count  (fifo_count)
);

// File: tb/tb_csprng_reseed_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: expected words are queued by the driver and popped by
// a monitor that reads the FIFO; a stub stands in for the cipher core.
module tb_csprng_reseed_ctrl;
    import csprng_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n, mix_seed_vld, host_seed_vld, test_mode, force_reseed;
    logic [SEED_W-1:0]  mix_seed, host_seed;
    logic [15:0]        reseed_limit;
    logic [ROUND_W-1:0] rounds_cfg, core_rounds;
    logic               seed_req, ready, core_init, core_next, core_vld, rd_en, rd_vld;
    logic [KEY_W-1:0]   core_key;
    logic [IV_W-1:0]    core_iv;
    logic [CTR_W-1:0]   core_ctr;
    logic [BLK_W-1:0]   core_data, core_blk;
    logic [WORD_W-1:0]  rd_data;

    csprng_reseed_ctrl dut (.*);

    int checks = 0, errors = 0;
    int init_cnt = 0, next_cnt = 0;
    logic [31:0] expq[$];

    function automatic logic [31:0] gen_word(seed_t s, int n, int j, logic [4:0] r);
        return (s.key[31:0] ^ s.data[j*32 +: 32]) + (s.ctr[31:0] + 32'(n)) * 32'h9E3779B1
               + 32'(j) + {r, 24'h0} + s.iv[31:0];
    endfunction

    function automatic seed_t mk_seed(int k);
        seed_t s;
        s.key = {8{32'(k) * 32'h1234_5677 + 32'h0BAD_F00D}};
        s.iv  = {4{32'(k) * 32'h0F0F_1357}};
        s.ctr = {32'h0, 32'(k) * 32'd1000};
        for (int j = 0; j < 16; j++) s.data[j*32 +: 32] = 32'(k) * 32'h0100_0000 + 32'(j) * 32'h0101_0101;
        return s;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_blocks(seed_t s, int nb, logic [4:0] r);
        for (int n = 0; n < nb; n++)
            for (int j = 0; j < 16; j++) expq.push_back(gen_word(s, n, j, r));
    endtask

    task automatic give_seed(seed_t s, bit host);
        while (!seed_req) @(negedge clk);
        if (host) begin host_seed = s; host_seed_vld = 1'b1; end
        else      begin mix_seed  = s; mix_seed_vld  = 1'b1; end
        @(negedge clk);
        host_seed_vld = 1'b0;
        mix_seed_vld  = 1'b0;
    endtask

    // Cipher core stub: fixed latency, one block per request.
    int stub_n = 0, dly = 0;
    bit pending = 1'b0;
    always @(posedge clk) begin
        core_vld <= 1'b0;
        if (core_init) stub_n <= 0;
        if (core_next) begin
            pending <= 1'b1;
            dly     <= 3;
        end else if (pending) begin
            if (dly == 1) begin
                seed_t s;
                s = {core_data, core_ctr, core_iv, core_key};
                for (int j = 0; j < 16; j++) core_blk[j*32 +: 32] <= gen_word(s, stub_n, j, core_rounds);
                core_vld <= 1'b1;
                stub_n   <= stub_n + 1;
                pending  <= 1'b0;
            end
            dly <= dly - 1;
        end
    end

    // Pulse counters on core control ports.
    always @(posedge clk) begin
        if (rst_n && core_init) init_cnt++;
        if (rst_n && core_next) next_cnt++;
    end

    // Monitor: compare the head word and pop it while words are expected (R4).
    always @(negedge clk) begin
        if (rst_n && rd_vld && expq.size() > 0) begin
            logic [31:0] e;
            e = expq.pop_front();
            chk(rd_data == e, "R4", "fifo word", 64'(rd_data), 64'(e));
            rd_en = 1'b1;
        end else begin
            rd_en = 1'b0;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seed_t s1, s3, s4, s5;
        int ib;
        rst_n = 1'b0; mix_seed_vld = 1'b0; host_seed_vld = 1'b0; test_mode = 1'b0;
        force_reseed = 1'b0; mix_seed = '0; host_seed = '0; reseed_limit = 16'd3;
        rounds_cfg = '0; rd_en = 1'b0; core_blk = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready == 1'b0, "R1", "ready after reset", 64'(ready), 0);
        chk(seed_req == 1'b1, "R1", "seed_req after reset", 64'(seed_req), 1);
        chk(rd_vld == 1'b0, "R1", "rd_vld after reset", 64'(rd_vld), 0);
        repeat (20) @(negedge clk);
        chk(next_cnt == 0, "R1", "no request before seed", 64'(next_cnt), 0);

        // Mixer seed, default rounds, limit of three blocks (R2 R3 R5)
        s1 = mk_seed(1);
        push_blocks(s1, 3, 5'd20);
        give_seed(s1, 1'b0);
        chk(ready == 1'b1, "R10", "ready after load", 64'(ready), 1);
        chk(core_init == 1'b1, "R2", "init pulse", 64'(core_init), 1);
        chk(core_key == s1.key, "R2", "key field", 64'(core_key), 64'(s1.key));
        chk(core_ctr == s1.ctr, "R2", "counter field", core_ctr, s1.ctr);
        chk(core_data == s1.data, "R2", "data field", 64'(core_data), 64'(s1.data));
        chk(core_rounds == 5'd20, "R3", "default rounds", 64'(core_rounds), 20);
        @(negedge clk);
        chk(core_init == 1'b0, "R2", "init one cycle", 64'(core_init), 0);
        wait (expq.size() == 0);
        repeat (40) @(negedge clk);
        chk(seed_req == 1'b1, "R5", "reseed after limit", 64'(seed_req), 1);
        chk(next_cnt == 3, "R5", "blocks per seed", 64'(next_cnt), 3);

        // Test mode: mixer ignored, host seed used, explicit rounds (R9 R3)
        test_mode = 1'b1; rounds_cfg = 5'd12;
        ib = init_cnt;
        mix_seed = mk_seed(2); mix_seed_vld = 1'b1;
        repeat (10) @(negedge clk);
        chk(init_cnt == ib, "R9", "mixer seed ignored", 64'(init_cnt), 64'(ib));
        chk(seed_req == 1'b1, "R9", "still waiting", 64'(seed_req), 1);
        mix_seed_vld = 1'b0;
        s3 = mk_seed(3);
        push_blocks(s3, 3, 5'd12);
        give_seed(s3, 1'b1);
        chk(core_rounds == 5'd12, "R3", "configured rounds", 64'(core_rounds), 12);
        chk(core_iv == s3.iv, "R9", "host nonce", 64'(core_iv), 64'(s3.iv));
        wait (expq.size() == 0);
        repeat (40) @(negedge clk);
        chk(ready == 1'b1, "R10", "ready held", 64'(ready), 1);
        chk(seed_req == 1'b1, "R5", "counter restarted", 64'(seed_req), 1);
        chk(next_cnt == 6, "R5", "blocks second seed", 64'(next_cnt), 6);

        // Back-pressure, forced reseed while stalled, merged force (R8 R6 R7 R5)
        test_mode = 1'b0; rounds_cfg = '0; reseed_limit = 16'd0;
        s4 = mk_seed(4);
        give_seed(s4, 1'b0);
        repeat (300) @(negedge clk);
        chk(next_cnt == 10, "R8", "stall at full fifo", 64'(next_cnt), 10);
        chk(seed_req == 1'b0, "R8", "no reseed while stalled", 64'(seed_req), 0);
        force_reseed = 1'b1; @(negedge clk); force_reseed = 1'b0;
        repeat (3) @(negedge clk);
        chk(seed_req == 1'b1, "R6", "force raises seed_req", 64'(seed_req), 1);
        chk(next_cnt == 10, "R6", "no block after force", 64'(next_cnt), 10);
        chk(rd_vld == 1'b1, "R6", "old words kept", 64'(rd_vld), 1);
        force_reseed = 1'b1; @(negedge clk); force_reseed = 1'b0;
        repeat (3) @(negedge clk);
        ib = init_cnt;
        s5 = mk_seed(5);
        push_blocks(s4, 4, 5'd20);
        push_blocks(s5, 8, 5'd20);
        give_seed(s5, 1'b0);
        wait (expq.size() == 0);
        repeat (100) @(negedge clk);
        chk(init_cnt == ib + 1, "R7", "single load after merged force", 64'(init_cnt), 64'(ib + 1));
        chk(seed_req == 1'b0, "R7", "no extra reseed", 64'(seed_req), 0);
        chk(seed_req == 1'b0, "R5", "limit zero never reseeds", 64'(seed_req), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule